// File: doc/BRIEF.md
# I2C Pointer-Addressed Register Slave

This block is a two-wire bus target that answers at the fixed 7-bit address 7'b1010000. It gives an external master access to a bank of 16-bit registers through an 8-bit pointer. A write transaction always loads the pointer from its first byte after the address. Any following bytes are grouped in pairs, high byte first, and each pair is written to the register that the pointer selects. A read transaction returns the register that the last written pointer selects, high byte first. The pointer keeps its value from one transaction to the next, so a master can set it once and read many times.

The register storage sits outside the block. The block presents the pointer on `regAddr` and samples `regRdData` when it captures a word for reading. It pulses `rdStrobe` for that capture so that other logic can react to the read. A committed write shows up as a one-cycle `regWrEn` pulse together with `regWrData`. The two identification words are generated inside the block. The bus lines arrive already filtered. The block synchronises them and detects START, STOP and clock edges. It pulls SDA low only through `sdaOe`, as an open-drain output.

The pointer space is split into four classes:
- 0x00–0x07, 0xFE and 0xFF are read-only.
- 0x08–0x14 are writable.
- 0x15–0xFD are unused.

The block does not hold SCL low to stretch the clock. The bus can run at any rate from 10 kHz to 400 kHz, provided the system clock is fast enough to sample every SCL phase.

Top module: `i2cPtrSlave`

## Requirements
- R1: An address byte of 7'b1010000 (with either R/W value) is acknowledged. Any other address is answered with NACK, and SDA stays released until the next START, including the bytes that follow.
- R2: The byte after a write-direction address byte is always loaded into the pointer. The pointer keeps its value across STOP and new transactions, and it resets to 0x00.
- R3: A write transaction that carries only the address and the pointer changes nothing except the pointer. A repeated START followed by a read-direction address then reads the register at that pointer.
- R4: A read sends the 16-bit word high byte first, with each byte bit 7 first. The word is taken from `regRdData` while `regAddr` equals the pointer. `rdStrobe` pulses for one cycle for every word captured.
- R5: If the master acknowledges the low byte, the block captures the same register again and sends it again from its high byte. If the master sends NACK, the block releases SDA until the next START or STOP.
- R6: A pointer byte in 0x15–0xFD is answered with NACK right after the pointer byte. The pointer is still loaded, and a later read at that pointer returns 0x0000.
- R7: For a pointer in 0x08–0x14, both data bytes are acknowledged. After the second byte has been acknowledged, `regWrEn` pulses for exactly one cycle with `regWrData` = {first byte, second byte} and `regAddr` = pointer.
- R8: For a pointer in 0x00–0x07, 0xFE or 0xFF, every data byte is answered with NACK and `regWrEn` never pulses.
- R9: A STOP after a single data byte discards that byte. No write takes place, and the next transaction starts a new byte pair.
- R10: Reads at pointer 0xFE return 0x5449 and reads at 0xFF return 0x1004, whatever `regRdData` holds.
- R11: After reset, `sdaOe` = 0, `regWrEn` = 0, `rdStrobe` = 0 and `regAddr` = 0x00. SDA is never driven while the block is idle or ignoring the bus.
- R12: More than two data bytes in one write are taken as successive pairs. Each pair commits to the same pointer, and the pointer does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Filtered SCL line level |
| sdaIn | input | 1 | Filtered SDA line level |
| sdaOe | output | 1 | When 1, pull SDA low (open drain) |
| regAddr | output | 8 | Current pointer, selects the register |
| regWrEn | output | 1 | One-cycle write commit strobe |
| regWrData | output | 16 | Word to write, valid with regWrEn |
| regRdData | input | 16 | Register contents at regAddr |
| rdStrobe | output | 1 | One-cycle pulse when a word is captured for a read |

## Verification
The bench covers the following corner cases:
- A foreign address followed by further bytes. A design that kept decoding after the NACK would acknowledge the later bytes.
- A pointer-only write followed by a repeated START read, and a fresh transaction that reads again without a pointer byte. A design that cleared the pointer at STOP would return register 0x00.
- A master ACK after the low byte. A design that advanced or stopped would not send the same word a second time.
- An unused pointer, a read-only pointer and the two identification addresses. A design that decoded the classes wrongly would acknowledge the wrong byte, write where it must not, or return the bank instead of the fixed words.
- Odd byte counts: one byte and then STOP, and four bytes in one transaction. A design that kept a half pair across transactions, or that advanced the pointer, would commit the wrong word or write to the wrong register.

// File: rtl/i2cPtrPkg.sv
package i2cPtrPkg;

  // Strobes from the control FSM to the datapath, valid for one cycle
  typedef struct packed {
    logic shiftIn;     // sample SDA into the receive shifter
    logic loadPtr;     // received byte becomes the pointer
    logic holdHi;      // keep received byte as high half of a write word
    logic commit;      // write {hold, received} to the pointed register
    logic loadWord;    // capture the read word at the pointer
    logic loadHiByte;  // put high half of the read word on the transmit shifter
    logic loadLoByte;  // put low half of the read word on the transmit shifter
    logic shiftOut;    // advance the transmit shifter by one bit
  } dpStrobe_t;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ADDR_ACK, S_PTR, S_PTR_ACK,
    S_WDATA, S_WDATA_ACK, S_TX, S_MACK, S_IGNORE
  } ctrlState_t;

  typedef enum logic [1:0] {ACC_UNUSED, ACC_RO, ACC_RW, ACC_ID} accKind_t;

endpackage

// File: rtl/i2cLineSense.sv
module i2cLineSense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclRise,
  output logic sclFall,
  output logic busStart,
  output logic busStop,
  output logic sdaBit
);
  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclQ, sdaQ;
  logic sclNow, sdaNow;

  assign sclNow = sclSync[SYNC_STAGES-1];
  assign sdaNow = sdaSync[SYNC_STAGES-1];

  // Lines idle high, so the synchronisers reset to 1
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclQ    <= sclNow;
      sdaQ    <= sdaNow;
    end
  end

  assign sclRise  = sclNow & ~sclQ;
  assign sclFall  = ~sclNow & sclQ;
  assign busStart = sclNow & sclQ & sdaQ & ~sdaNow;
  assign busStop  = sclNow & sclQ & ~sdaQ & sdaNow;
  assign sdaBit   = sdaNow;

endmodule

// File: rtl/i2cPtrCtrl.sv
module i2cPtrCtrl
  import i2cPtrPkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclRise,
  input  logic      sclFall,
  input  logic      busStart,
  input  logic      busStop,
  input  logic      sdaBit,
  input  logic      addrMatch,
  input  logic      rwBit,
  input  logic      ptrValid,
  input  logic      ptrWritable,
  input  logic      txMsb,
  output dpStrobe_t stb,
  output logic      sdaOe
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  ctrlState_t stQ, stNxt;
  logic [CNT_W-1:0] cntQ, cntNxt;
  logic ackQ, ackNxt;     // block acknowledges in the current ack slot
  logic loQ, loNxt;       // second byte of a pair / low byte on the wire
  logic mAckQ, mAckNxt;   // master acknowledged the byte just sent
  logic byteDone;

  assign byteDone = sclFall && (cntQ == CNT_FULL);

  always_comb begin
    stNxt   = stQ;
    cntNxt  = cntQ;
    ackNxt  = ackQ;
    loNxt   = loQ;
    mAckNxt = mAckQ;
    stb     = '0;
    if (busStop) begin
      stNxt  = S_IDLE;
      ackNxt = 1'b0;
    end else if (busStart) begin
      stNxt  = S_ADDR;
      cntNxt = '0;
      loNxt  = 1'b0;
      ackNxt = 1'b0;
    end else begin
      unique case (stQ)
        S_ADDR, S_PTR, S_WDATA: begin
          if (sclRise && cntQ != CNT_FULL) begin
            stb.shiftIn = 1'b1;
            cntNxt      = cntQ + CNT_W'(1);
          end else if (byteDone) begin
            cntNxt = '0;
            if (stQ == S_ADDR) begin
              stNxt  = addrMatch ? S_ADDR_ACK : S_IGNORE;
              ackNxt = addrMatch;
            end else if (stQ == S_PTR) begin
              stb.loadPtr = 1'b1;
              stNxt       = S_PTR_ACK;
              ackNxt      = ptrValid;
            end else begin
              stb.holdHi = ~loQ;
              stNxt      = S_WDATA_ACK;
              ackNxt     = ptrWritable;
            end
          end
        end
        S_ADDR_ACK: begin
          if (sclFall) begin
            ackNxt = 1'b0;
            cntNxt = '0;
            loNxt  = 1'b0;
            if (rwBit) begin
              stNxt          = S_TX;
              stb.loadWord   = 1'b1;
              stb.loadHiByte = 1'b1;
            end else begin
              stNxt = S_PTR;
            end
          end
        end
        S_PTR_ACK: begin
          if (sclFall) begin
            stNxt  = ackQ ? S_WDATA : S_IGNORE;
            ackNxt = 1'b0;
            loNxt  = 1'b0;
          end
        end
        S_WDATA_ACK: begin
          if (sclFall) begin
            stb.commit = loQ & ackQ;
            loNxt      = ~loQ;
            ackNxt     = 1'b0;
            stNxt      = S_WDATA;
          end
        end
        S_TX: begin
          if (sclFall) begin
            if (cntQ == CNT_LAST) begin
              stNxt  = S_MACK;
              cntNxt = '0;
            end else begin
              stb.shiftOut = 1'b1;
              cntNxt       = cntQ + CNT_W'(1);
            end
          end
        end
        S_MACK: begin
          if (sclRise) begin
            mAckNxt = ~sdaBit;
          end else if (sclFall) begin
            if (mAckQ) begin
              stNxt  = S_TX;
              cntNxt = '0;
              if (loQ) begin
                loNxt          = 1'b0;
                stb.loadWord   = 1'b1;
                stb.loadHiByte = 1'b1;
              end else begin
                loNxt          = 1'b1;
                stb.loadLoByte = 1'b1;
              end
            end else begin
              stNxt = S_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ   <= S_IDLE;
      cntQ  <= '0;
      ackQ  <= 1'b0;
      loQ   <= 1'b0;
      mAckQ <= 1'b0;
    end else begin
      stQ   <= stNxt;
      cntQ  <= cntNxt;
      ackQ  <= ackNxt;
      loQ   <= loNxt;
      mAckQ <= mAckNxt;
    end
  end

  assign sdaOe = ((stQ == S_ADDR_ACK || stQ == S_PTR_ACK || stQ == S_WDATA_ACK) && ackQ)
               || (stQ == S_TX && !txMsb);

  // R1: a foreign address leaves SDA released and the FSM deaf
  assert_foreign_nack_R1: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == S_ADDR && !busStart && !busStop && byteDone && !addrMatch)
      |=> (stQ == S_IGNORE && !sdaOe));

  // R6: an unused pointer is not acknowledged
  assert_unused_nack_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == S_PTR && !busStart && !busStop && byteDone && !ptrValid)
      |=> (stQ == S_PTR_ACK && !sdaOe));

  // R11: no drive while idle or ignoring the bus
  assert_idle_release_R11: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == S_IDLE || stQ == S_IGNORE) |-> !sdaOe);

endmodule

// File: rtl/i2cPtrData.sv
module i2cPtrData
  import i2cPtrPkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int DEV_ADDR    = 7'h50,
  parameter int RO_FIRST    = 8'h00,
  parameter int RO_LAST     = 8'h07,
  parameter int RW_FIRST    = 8'h08,
  parameter int RW_LAST     = 8'h14,
  parameter int MFR_ID_ADDR = 8'hFE,
  parameter int DEV_ID_ADDR = 8'hFF,
  parameter int MFR_ID      = 16'h5449,
  parameter int DEV_ID      = 16'h1004
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic              sdaBit,
  input  logic [DATA_W-1:0] regRdData,
  output logic              addrMatch,
  output logic              rwBit,
  output logic              ptrValid,
  output logic              ptrWritable,
  output logic              txMsb,
  output logic [DATA_W/2-1:0] regAddr,
  output logic              regWrEn,
  output logic [DATA_W-1:0] regWrData,
  output logic              rdStrobe
);
  localparam int BYTE_W = DATA_W / 2;

  logic [BYTE_W-1:0] rxSh, ptrQ, hiHold, txSh;
  logic [DATA_W-1:0] wordQ, readWord;
  accKind_t rxKind, ptrKind;

  function automatic accKind_t classify(input logic [BYTE_W-1:0] p);
    int v;
    v = int'(p);
    if (v == MFR_ID_ADDR || v == DEV_ID_ADDR) return ACC_ID;
    if (v >= RO_FIRST && v <= RO_LAST) return ACC_RO;
    if (v >= RW_FIRST && v <= RW_LAST) return ACC_RW;
    return ACC_UNUSED;
  endfunction

  assign rxKind      = classify(rxSh);
  assign ptrKind     = classify(ptrQ);
  assign addrMatch   = (int'(rxSh[BYTE_W-1:1]) == DEV_ADDR);
  assign rwBit       = rxSh[0];
  assign ptrValid    = (rxKind != ACC_UNUSED);
  assign ptrWritable = (ptrKind == ACC_RW);
  assign txMsb       = txSh[BYTE_W-1];
  assign regAddr     = ptrQ;

  always_comb begin
    unique case (ptrKind)
      ACC_ID:     readWord = (int'(ptrQ) == MFR_ID_ADDR) ? DATA_W'(MFR_ID) : DATA_W'(DEV_ID);
      ACC_UNUSED: readWord = '0;
      default:    readWord = regRdData;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh      <= '0;
      ptrQ      <= '0;
      hiHold    <= '0;
      txSh      <= '1;
      wordQ     <= '0;
      regWrEn   <= 1'b0;
      regWrData <= '0;
      rdStrobe  <= 1'b0;
    end else begin
      regWrEn  <= stb.commit;
      rdStrobe <= stb.loadWord;
      if (stb.shiftIn) rxSh <= {rxSh[BYTE_W-2:0], sdaBit};
      if (stb.loadPtr) ptrQ <= rxSh;
      if (stb.holdHi)  hiHold <= rxSh;
      if (stb.commit)  regWrData <= {hiHold, rxSh};
      if (stb.loadWord) wordQ <= readWord;
      if (stb.loadHiByte)
        txSh <= stb.loadWord ? readWord[DATA_W-1:BYTE_W] : wordQ[DATA_W-1:BYTE_W];
      else if (stb.loadLoByte)
        txSh <= wordQ[BYTE_W-1:0];
      else if (stb.shiftOut)
        txSh <= {txSh[BYTE_W-2:0], 1'b1};
    end
  end

  // R8: a commit only ever reaches a writable register
  assert_ro_write_blocked_R8: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> (classify(regAddr) == ACC_RW));

  // R7: the write strobe is a single-cycle pulse
  assert_wren_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  // R4: one read strobe per captured word
  assert_rd_strobe_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe |=> !rdStrobe);

endmodule

// File: rtl/i2cPtrSlave.sv
module i2cPtrSlave
  import i2cPtrPkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DEV_ADDR    = 7'h50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  output logic [DATA_W/2-1:0] regAddr,
  output logic              regWrEn,
  output logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] regRdData,
  output logic              rdStrobe
);
  localparam int BYTE_W = DATA_W / 2;

  logic sclRise, sclFall, busStart, busStop, sdaBit;
  logic addrMatch, rwBit, ptrValid, ptrWritable, txMsb;
  dpStrobe_t stb;

  i2cLineSense #(.SYNC_STAGES(SYNC_STAGES)) i_lineSense (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclRise(sclRise), .sclFall(sclFall), .busStart(busStart),
    .busStop(busStop), .sdaBit(sdaBit)
  );

  i2cPtrCtrl #(.BYTE_W(BYTE_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .busStart(busStart), .busStop(busStop), .sdaBit(sdaBit),
    .addrMatch(addrMatch), .rwBit(rwBit), .ptrValid(ptrValid),
    .ptrWritable(ptrWritable), .txMsb(txMsb), .stb(stb), .sdaOe(sdaOe)
  );

  i2cPtrData #(.DATA_W(DATA_W), .DEV_ADDR(DEV_ADDR)) i_data (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaBit(sdaBit),
    .regRdData(regRdData), .addrMatch(addrMatch), .rwBit(rwBit),
    .ptrValid(ptrValid), .ptrWritable(ptrWritable), .txMsb(txMsb),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .rdStrobe(rdStrobe)
  );

endmodule

// File: tb/test_i2cPtrSlave.sv
module test_i2cPtrSlave;
  localparam int QTR = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN;
  logic sclM, sdaM;
  logic sdaOe;
  logic sdaLine;
  logic [7:0] regAddr;
  logic regWrEn, rdStrobe;
  logic [15:0] regWrData, regRdData;

  logic [15:0] bank [256];
  logic preEn;
  logic [7:0] preAddr;
  logic [15:0] preData;
  int wrCount = 0, rdCount = 0;
  logic [7:0] lastWrAddr = 8'h00;
  logic [15:0] lastWrData = 16'h0000;
  int vectors = 0, miscompares = 0;
  bit timedOut = 0;

  assign sdaLine   = sdaM & ~sdaOe;
  assign regRdData = bank[regAddr];

  i2cPtrSlave i_i2cPtrSlave (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .rdStrobe(rdStrobe)
  );

  // Register bank model owned by one process
  always @(negedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) bank[i] = 16'h0000;
    end else begin
      if (preEn) bank[preAddr] = preData;
      if (regWrEn) begin
        wrCount++;
        lastWrAddr = regAddr;
        lastWrData = regWrData;
        bank[regAddr] = regWrData;
      end
      if (rdStrobe) rdCount++;
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [15:0] d);
    @(posedge clk); preAddr = a; preData = d; preEn = 1'b1;
    @(posedge clk); preEn = 1'b0;
  endtask

  task automatic waitQ(input int n);
    repeat (n * QTR) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; sclM = 1'b1; waitQ(1);
    sdaM = 1'b0; waitQ(1);
    sclM = 1'b0; waitQ(1);
  endtask

  task automatic busRepStart();
    sdaM = 1'b1; waitQ(1);
    sclM = 1'b1; waitQ(1);
    sdaM = 1'b0; waitQ(1);
    sclM = 1'b0; waitQ(1);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ(1);
    sclM = 1'b1; waitQ(1);
    sdaM = 1'b1; waitQ(2);
  endtask

  task automatic writeBit(input logic b);
    sdaM = b; waitQ(1);
    sclM = 1'b1; waitQ(2);
    sclM = 1'b0; waitQ(1);
  endtask

  task automatic readBit(output logic b);
    sdaM = 1'b1; waitQ(1);
    sclM = 1'b1; waitQ(1);
    b = sdaLine; waitQ(1);
    sclM = 1'b0; waitQ(1);
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) writeBit(v[i]);
    readBit(b);
    ack = ~b;
  endtask

  task automatic recvByte(input logic mAck, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      readBit(b);
      v[i] = b;
    end
    writeBit(~mAck);
  endtask

  task automatic setPtr(input logic [7:0] p, output logic aAck, output logic pAck);
    busStart();
    sendByte(8'hA0, aAck);
    sendByte(p, pAck);
  endtask

  task automatic readOneWord(output logic [15:0] w, output logic aAck);
    logic [7:0] hi, lo;
    sendByte(8'hA1, aAck);
    recvByte(1'b1, hi);
    recvByte(1'b0, lo);
    w = {hi, lo};
  endtask

  // ---------------- scenarios ----------------
  task automatic tReset();
    check("R11", "sdaOe after reset", sdaOe, 0);
    check("R11", "regWrEn after reset", regWrEn, 0);
    check("R11", "rdStrobe after reset", rdStrobe, 0);
    check("R2", "pointer after reset", regAddr, 8'h00);
  endtask

  task automatic tForeignAddr();
    logic a1, a2;
    busStart();
    sendByte(8'hA2, a1);
    sendByte(8'hA0, a2);
    busStop();
    check("R1", "foreign address ack", a1, 0);
    check("R1", "byte after foreign address ack", a2, 0);
    check("R1", "pointer untouched", regAddr, 8'h00);
  endtask

  task automatic tWriteReg();
    logic aA, pA, d1, d2;
    int w0 = wrCount;
    setPtr(8'h09, aA, pA);
    sendByte(8'hBE, d1);
    sendByte(8'hEF, d2);
    busStop();
    check("R1", "own address ack", aA, 1);
    check("R7", "pointer ack", pA, 1);
    check("R7", "data byte acks", {d1, d2}, 2'b11);
    check("R7", "write count", wrCount - w0, 1);
    check("R7", "write address", lastWrAddr, 8'h09);
    check("R7", "write data", lastWrData, 16'hBEEF);
  endtask

  task automatic tPtrOnlyRead();
    logic aA, pA, rA;
    logic [15:0] w;
    int r0;
    int w0 = wrCount;
    poke(8'h03, 16'h1234);
    r0 = rdCount;
    setPtr(8'h03, aA, pA);
    busRepStart();
    readOneWord(w, rA);
    busStop();
    check("R3", "pointer-only write commits nothing", wrCount - w0, 0);
    check("R3", "read address ack", rA, 1);
    check("R4", "read word high then low", w, 16'h1234);
    check("R4", "read strobe count", rdCount - r0, 1);
  endtask

  task automatic tPersist();
    logic rA;
    logic [15:0] w;
    busStart();
    readOneWord(w, rA);
    busStop();
    check("R2", "pointer persists across transactions", w, 16'h1234);
    check("R2", "regAddr holds pointer", regAddr, 8'h03);
  endtask

  task automatic tReread();
    logic aA, pA, rA;
    logic [7:0] b0, b1, b2, b3;
    int r0;
    poke(8'h0A, 16'hA55A);
    r0 = rdCount;
    setPtr(8'h0A, aA, pA);
    busRepStart();
    sendByte(8'hA1, rA);
    recvByte(1'b1, b0);
    recvByte(1'b1, b1);
    recvByte(1'b1, b2);
    recvByte(1'b0, b3);
    busStop();
    check("R5", "repeated word bytes", {b0, b1, b2, b3}, 32'hA55AA55A);
    check("R5", "strobe per capture", rdCount - r0, 2);
    check("R5", "SDA released after master NACK", sdaOe, 0);
  endtask

  task automatic tUnused();
    logic aA, pA, rA;
    logic [15:0] w;
    poke(8'h20, 16'hFFFF);
    setPtr(8'h20, aA, pA);
    busStop();
    check("R6", "unused pointer nack", pA, 0);
    check("R6", "unused pointer still loaded", regAddr, 8'h20);
    busStart();
    readOneWord(w, rA);
    busStop();
    check("R6", "unused location reads zero", w, 16'h0000);
  endtask

  task automatic tReadOnly();
    logic aA, pA, d1, d2, d3;
    int w0 = wrCount;
    setPtr(8'h05, aA, pA);
    sendByte(8'h12, d1);
    sendByte(8'h34, d2);
    busStop();
    check("R8", "result register pointer ack", pA, 1);
    check("R8", "data bytes nacked", {d1, d2}, 2'b00);
    setPtr(8'hFF, aA, pA);
    sendByte(8'h56, d3);
    busStop();
    check("R8", "id register data nack", d3, 0);
    check("R8", "no write to read-only", wrCount - w0, 0);
  endtask

  task automatic tIds();
    logic aA, pA, rA;
    logic [15:0] w;
    poke(8'hFE, 16'h0000);
    poke(8'hFF, 16'hFFFF);
    setPtr(8'hFE, aA, pA);
    busRepStart();
    readOneWord(w, rA);
    busStop();
    check("R10", "manufacturer word", w, 16'h5449);
    setPtr(8'hFF, aA, pA);
    busRepStart();
    readOneWord(w, rA);
    busStop();
    check("R10", "device word", w, 16'h1004);
  endtask

  task automatic tHalfWrite();
    logic aA, pA, d1, d2, d3;
    int w0 = wrCount;
    setPtr(8'h0C, aA, pA);
    sendByte(8'h77, d1);
    busStop();
    check("R9", "single byte acked", d1, 1);
    check("R9", "single byte discarded", wrCount - w0, 0);
    setPtr(8'h0D, aA, pA);
    sendByte(8'h11, d2);
    sendByte(8'h22, d3);
    busStop();
    check("R9", "next pair fresh", lastWrData, 16'h1122);
    check("R9", "next pair address", lastWrAddr, 8'h0D);
  endtask

  task automatic tMultiPair();
    logic aA, pA, rA;
    logic [3:0] acks;
    logic [15:0] w;
    int w0 = wrCount;
    setPtr(8'h11, aA, pA);
    sendByte(8'h01, acks[3]);
    sendByte(8'h02, acks[2]);
    sendByte(8'h03, acks[1]);
    sendByte(8'h04, acks[0]);
    busStop();
    check("R12", "all four bytes acked", acks, 4'hF);
    check("R12", "two commits", wrCount - w0, 2);
    check("R12", "pointer not advanced", regAddr, 8'h11);
    check("R12", "last pair wins", lastWrData, 16'h0304);
    busStart();
    readOneWord(w, rA);
    busStop();
    check("R12", "readback of same register", w, 16'h0304);
  endtask

  task automatic runAll();
    tReset();
    tForeignAddr();
    tWriteReg();
    tPtrOnlyRead();
    tPersist();
    tReread();
    tUnused();
    tReadOnly();
    tIds();
    tHalfWrite();
    tMultiPair();
  endtask

  initial begin
    rstN = 1'b0; sclM = 1'b1; sdaM = 1'b1;
    preEn = 1'b0; preAddr = 8'h00; preData = 16'h0000;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    fork
      runAll();
      begin
        repeat (150000) @(posedge clk);
        timedOut = 1;
      end
    join_any
    if (timedOut) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule